// File: doc/BRIEF.md
# Controller Hotkey Save-State Slot Selector

This block watches the decoded state of a 12-button game controller, sampled once per video frame, and turns button chords into save-state commands. A Start+R chord raises a one-cycle save request and a Start+L chord raises a one-cycle load request. A command fires only on the frame where its chord becomes complete, and it cannot fire again until both chord buttons have been let go. Holding Select while pressing a D-pad direction picks one of four state slots. This only works while the slot option is enabled. Otherwise slot 1 is reported.

Once the state mover reports that a load has finished, the block raises a resume-hold signal. The hold keeps the game paused for a programmable number of frames, which gives the player time to release the hotkey buttons before play continues.

Top module: `hotkey_slot_ctrl`

## Requirements
- R1: The button word is active high, with bit 0 Up, bit 1 Down, bit 2 Left, bit 3 Right, bit 4 Start, bit 5 Select, bit 6 L and bit 7 R. Bits 11:8 (face buttons) have no effect. Buttons are captured only on a clock edge where `frame_tick` is high, so changes between frame ticks are ignored.
- R2: If the frame sampled at edge k holds Start and L but not R, and the load chord is armed, `load_req` is high for exactly the one cycle between edges k+1 and k+2.
- R3: If the frame sampled at edge k holds Start and R but not L, and the save chord is armed, `save_req` is high for exactly the one cycle between edges k+1 and k+2.
- R4: A frame with Start, L and R all held produces neither request, and `save_req` and `load_req` are never high together.
- R5: After a chord fires, it is disarmed. It is re-armed only by a sampled frame in which both of its buttons (Start and L, or Start and R) are released. Both chords are armed after reset.
- R6: `slot_sel` encodes slot 1 to 4 as 0 to 3. While `slot_en` is 1, a sampled frame with Select and at least one D-pad direction sets the slot with priority Up (0), Right (1), Down (2), Left (3). The new value is visible from edge k+1.
- R7: While `slot_en` is 0, `slot_sel` reads 0 and Select+D-pad frames do not change the stored slot. When the option is enabled again, the earlier stored slot reappears.
- R8: `resume_hold` rises on the edge after `load_done` is seen, with the count loaded from `load_delay` = N. It stays high through N sampled frame ticks and falls on the edge of tick N+1. With N = 0, it falls on the first tick.
- R9: A `load_done` seen while the hold is active restarts the count from `load_delay`. A `load_done` takes precedence over a frame tick in the same cycle.
- R10: After reset, `save_req` and `load_req` are low, `slot_sel` is 0 and `resume_hold` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per video frame; samples `btn` |
| btn | input | 12 | Decoded controller button word, active high |
| slot_en | input | 1 | Enables slot selection by hotkey |
| load_delay | input | DLY_W (8) | Frames to hold after a load completes |
| load_done | input | 1 | One-cycle strobe: state load finished |
| save_req | output | 1 | One-cycle save command |
| load_req | output | 1 | One-cycle load command |
| slot_sel | output | 2 | Selected slot, 0 = slot 1 |
| resume_hold | output | 1 | Keeps the game paused after a load |

## Verification
The bench drives every combination of the eight meaningful buttons as a chain of frames, in counting order and in a scrambled order. This exercises chord entry, repeated holding, release and re-arming along many different transitions. Face-button bits are set from the same sweep, which shows that they are ignored. The three-button and multi-direction cases separate the exclusion rule from the D-pad priority. The sweep runs once with the slot option off and once with it on, which separates forcing the output to 0 from suppressing the update of the stored slot. A button change made between ticks shows that sampling happens only on ticks. Hold runs with delays 0, 1 and 3, plus a restart in the middle of a hold, pin down the exact tick on which the hold is released.

// File: rtl/hk_pkg.sv
package hk_pkg;
  localparam int BTN_W  = 12;
  localparam int KEY_W  = 8;
  localparam int SLOT_W = 2;

  localparam int B_UP    = 0;
  localparam int B_DOWN  = 1;
  localparam int B_LEFT  = 2;
  localparam int B_RIGHT = 3;
  localparam int B_START = 4;
  localparam int B_SEL   = 5;
  localparam int B_L     = 6;
  localparam int B_R     = 7;

  // dpad = {right, left, down, up}; priority Up, Right, Down, Left
  function automatic logic [SLOT_W-1:0] pick_slot(input logic [3:0] dpad,
                                                 input logic [SLOT_W-1:0] keep);
    if (dpad[0])      return 2'd0;
    else if (dpad[3]) return 2'd1;
    else if (dpad[1]) return 2'd2;
    else if (dpad[2]) return 2'd3;
    else              return keep;
  endfunction

  function automatic logic [7:0] hold_step(input logic [7:0] cnt);
    return cnt - 8'd1;
  endfunction
endpackage

// File: rtl/hk_frame_sampler.sv
module hk_frame_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_tick,
  input  logic [W-1:0] btn_in,
  output logic [W-1:0] btn_q,
  output logic         smp_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_q     <= '0;
      smp_pulse <= 1'b0;
    end else begin
      smp_pulse <= frame_tick;
      if (frame_tick) btn_q <= btn_in;
    end
  end

  // R1: captured buttons move only on a frame tick
  a_r1_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(btn_q));
endmodule

// File: rtl/hk_chord_oneshot.sv
module hk_chord_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic key_a,
  input  logic key_b,
  input  logic key_x,
  output logic fire
);
  logic armed;
  logic chord_full;
  logic chord_free;

  assign chord_full = key_a & key_b & ~key_x;
  assign chord_free = ~key_a & ~key_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (smp) begin
        if (chord_free) armed <= 1'b1;
        else if (chord_full && armed) begin
          fire  <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end

  // R2/R3: a request lasts a single cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R4: a request requires the exclusive chord in the captured frame
  a_r4_exclusive_chord: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(key_a && key_b && !key_x));
  // R5: once fired, no further fire until a release frame is seen
  a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !armed);
endmodule

// File: rtl/hk_slot_reg.sv
module hk_slot_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp,
  input  logic       slot_en,
  input  logic       sel,
  input  logic [3:0] dpad,
  output logic [1:0] slot_out
);
  import hk_pkg::*;

  logic [SLOT_W-1:0] slot_q;
  logic              pick_evt;

  assign pick_evt = smp & slot_en & sel & (|dpad);

  always_ff @(posedge clk) begin
    if (!rst_n)        slot_q <= '0;
    else if (pick_evt) slot_q <= pick_slot(dpad, slot_q);
  end

  assign slot_out = slot_en ? slot_q : '0;

  // R6/R7: stored slot changes only on an enabled Select+D-pad frame
  a_r7_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_evt |=> $stable(slot_q));
  // R6: Up has top priority
  a_r6_up_first: assert property (@(posedge clk) disable iff (!rst_n)
    pick_evt && dpad[0] |=> slot_q == 2'd0);
endmodule

// File: rtl/hk_resume_timer.sv
module hk_resume_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             load_done,
  input  logic [DLY_W-1:0] load_delay,
  output logic             hold
);
  logic [DLY_W-1:0] cnt;
  logic             expire;

  assign expire = hold & frame_tick & ~load_done & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= 1'b0;
      cnt  <= '0;
    end else if (load_done) begin
      hold <= 1'b1;
      cnt  <= load_delay;
    end else if (hold && frame_tick) begin
      if (cnt == '0) hold <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R8: hold only starts after a load_done
  a_r8_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(load_done));
  // R8: no release without a frame tick
  a_r8_keep_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !frame_tick && !load_done |=> hold);
  // R9: load_done wins over a tick
  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> hold);
  // R8: release happens exactly on expiry
  a_r8_fall_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(expire));
endmodule

// File: rtl/hotkey_slot_ctrl.sv
module hotkey_slot_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [11:0]      btn,
  input  logic             slot_en,
  input  logic [DLY_W-1:0] load_delay,
  input  logic             load_done,
  output logic             save_req,
  output logic             load_req,
  output logic [1:0]       slot_sel,
  output logic             resume_hold
);
  import hk_pkg::*;

  logic [KEY_W-1:0] keys_q;
  logic             smp_pulse;
  logic             unused_face;

  assign unused_face = ^btn[BTN_W-1:KEY_W];

  hk_frame_sampler #(.W(KEY_W)) i_sampler (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .btn_in(btn[KEY_W-1:0]), .btn_q(keys_q), .smp_pulse(smp_pulse));

  // index 0: save (Start+R, not L), index 1: load (Start+L, not R)
  logic [1:0] fire_v;
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_chord
      localparam int KB = (g == 0) ? B_R : B_L;
      localparam int KX = (g == 0) ? B_L : B_R;
      hk_chord_oneshot i_chord (
        .clk(clk), .rst_n(rst_n), .smp(smp_pulse),
        .key_a(keys_q[B_START]), .key_b(keys_q[KB]), .key_x(keys_q[KX]),
        .fire(fire_v[g]));
    end
  endgenerate

  assign save_req = fire_v[0];
  assign load_req = fire_v[1];

  hk_slot_reg i_slot (
    .clk(clk), .rst_n(rst_n), .smp(smp_pulse), .slot_en(slot_en),
    .sel(keys_q[B_SEL]),
    .dpad({keys_q[B_RIGHT], keys_q[B_LEFT], keys_q[B_DOWN], keys_q[B_UP]}),
    .slot_out(slot_sel));

  hk_resume_timer #(.DLY_W(DLY_W)) i_resume (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .load_done(load_done), .load_delay(load_delay), .hold(resume_hold));

  // R4: commands are mutually exclusive
  a_r4_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_req && load_req));
  // R2/R3: commands appear only one cycle after a frame sample
  a_r2_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req || load_req) |-> $past(smp_pulse));
endmodule

// File: tb/test_hotkey_slot_ctrl.sv
module test_hotkey_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [11:0] btn = '0;
  logic        slot_en = 1'b0;
  logic [7:0]  load_delay = '0;
  logic        load_done = 1'b0;
  logic        save_req, load_req, resume_hold;
  logic [1:0]  slot_sel;

  int tests = 0;
  int fails = 0;
  logic m_sr = 1'b1, m_lr = 1'b1;
  logic [1:0] m_slot = 2'd0;
  logic done_flag = 1'b0;

  always #4 clk = ~clk;

  hotkey_slot_ctrl i_hotkey_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .btn(btn),
    .slot_en(slot_en), .load_delay(load_delay), .load_done(load_done),
    .save_req(save_req), .load_req(load_req), .slot_sel(slot_sel),
    .resume_hold(resume_hold));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_frame(input logic [11:0] b);
    logic up, dn, lf, rt, st, se, l, r, es, el;
    up = b[0]; dn = b[1]; lf = b[2]; rt = b[3];
    st = b[4]; se = b[5]; l = b[6]; r = b[7];
    es = st && r && !l && m_sr;
    el = st && l && !r && m_lr;
    if (!st && !r) m_sr = 1'b1; else if (es) m_sr = 1'b0;
    if (!st && !l) m_lr = 1'b1; else if (el) m_lr = 1'b0;
    if (slot_en && se) begin
      if (up) m_slot = 2'd0;
      else if (rt) m_slot = 2'd1;
      else if (dn) m_slot = 2'd2;
      else if (lf) m_slot = 2'd3;
    end
    @(negedge clk); btn = b; frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    @(negedge clk);
    chk("R3 save", int'(save_req), int'(es));
    chk("R2 load", int'(load_req), int'(el));
    chk("R6/R7 slot", int'(slot_sel), slot_en ? int'(m_slot) : 0);
    @(negedge clk);
    chk("R2/R3 one-cycle", int'(save_req | load_req), 0);
  endtask

  task automatic sweep(input int mult);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] k;
      k = 8'((i * mult) & 255);
      do_frame({k[3:0] ^ 4'h5, k});
    end
  endtask

  task automatic hold_run(input int n);
    load_delay = 8'(n);
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
    chk("R8 hold rises", int'(resume_hold), 1);
    repeat (3) @(negedge clk);
    chk("R8 hold between ticks", int'(resume_hold), 1);
    for (int t = 1; t <= n + 1; t++) begin
      do_frame(12'h000);
      chk("R8 hold count", int'(resume_hold), (t <= n) ? 1 : 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 save", int'(save_req), 0);
    chk("R10 load", int'(load_req), 0);
    chk("R10 slot", int'(slot_sel), 0);
    chk("R10 hold", int'(resume_hold), 0);

    // R4 three-button chord gives nothing
    do_frame(12'h0D0);
    do_frame(12'h000);

    // R1 glitch between ticks ignored
    do_frame(12'h010);
    @(negedge clk); btn = 12'h050;
    @(negedge clk); btn = 12'h010;
    repeat (3) begin
      @(negedge clk);
      chk("R1 no load on glitch", int'(load_req), 0);
    end
    do_frame(12'h000);

    // R5 re-arm: hold Start+R, then keep Start, release R, press again
    do_frame(12'h090);
    do_frame(12'h090);
    do_frame(12'h010);
    do_frame(12'h090);
    do_frame(12'h080);
    do_frame(12'h000);
    do_frame(12'h090);
    do_frame(12'h000);

    // R7 disabled sweep, then R6 enabled sweeps
    slot_en = 1'b0;
    sweep(1);
    slot_en = 1'b1;
    do_frame(12'h024);
    slot_en = 1'b0;
    do_frame(12'h021);
    slot_en = 1'b1;
    @(negedge clk);
    chk("R7 slot kept while disabled", int'(slot_sel), 3);
    sweep(1);
    sweep(37);
    do_frame(12'h02F);

    // R8 hold delays, R9 restart
    hold_run(0);
    hold_run(1);
    hold_run(3);
    load_delay = 8'd2;
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
    do_frame(12'h000);
    do_frame(12'h000);
    @(negedge clk); load_done = 1'b1; frame_tick = 1'b1;
    @(negedge clk); load_done = 1'b0; frame_tick = 1'b0;
    chk("R9 restart holds", int'(resume_hold), 1);
    do_frame(12'h000);
    do_frame(12'h000);
    chk("R9 restart still held", int'(resume_hold), 1);
    do_frame(12'h000);
    chk("R9 restart release", int'(resume_hold), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule